// File: doc/BRIEF.md
# Capture Timer with Square-Wave Output

This block is a free-running up-counter with a parameterised width of 16 bits by default. Software picks one of two count sources. In the first, the counter advances on a tick that an external prescaler supplies. In the second, it advances on rising edges of an asynchronous event pin. A compare register sets the count at which the counter returns to zero. Each return to zero also flips a dedicated output pin, so the pin carries a square wave with a 50% duty cycle. Its period is twice (compare + 1) counted steps.

A second asynchronous pin requests a capture. On each rising edge of this pin, the count at that moment is copied into a capture register, which software can read. The block raises one-cycle interrupt pulses for captures and for compare matches. A run-enable input stops the counter where it is. The counter is cleared only by reset or by a compare match.

Top module: `evt_capture_timer`

## Requirements
- R1: After reset the count is 0, the capture register is 0, the square-wave output is low, both interrupt pulses are low, and the compare register holds all ones.
- R2: When the source select is 0 (tick source), the count advances by one in every clock cycle in which run and tick are both high. Edges on the event pin have no effect.
- R3: When the source select is 1 (event source), the count advances by one for each rising edge of the event pin, provided the pin stays high for at least one clock cycle and then low for at least one clock cycle. The tick input has no effect.
- R4: When an advance occurs while the count equals the compare value, the count becomes 0 instead of compare + 1, and the square-wave output inverts. The output period is therefore 2*(compare+1) advances.
- R5: The compare interrupt is high for exactly one cycle after each compare match, and at no other time.
- R6: Each rising edge of the capture pin loads the count into the capture register and raises the capture interrupt for one cycle. The edge passes through a two-flop synchronizer, so a level change just before clock edge k is acted on at edge k+2. The capture register holds its value between captures.
- R7: When a capture and a compare clear fall in the same cycle, the capture register receives the count as it was before the clear.
- R8: While run is low, the count and the square-wave output hold their values whatever the tick and event inputs do.
- R9: A write strobe loads the write data into the compare register, and the new value governs matches from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick, used when the tick source is selected |
| src_sel_i | input | 1 | Count source: 0 = tick, 1 = event pin |
| run_i | input | 1 | Run enable; low freezes the count |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | CW | Compare register write data |
| evt_i | input | 1 | Asynchronous external event pin |
| cap_i | input | 1 | Asynchronous external capture request pin |
| cap_val_o | output | CW | Capture register contents |
| sq_o | output | 1 | Square-wave output, inverted on each compare match |
| cap_irq_o | output | 1 | One-cycle capture interrupt pulse |
| cmp_irq_o | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
The bench builds the timer with a counter width of 6. This makes all 64 compare values small enough to sweep exhaustively in tick mode, including a compare of 0 and the reset default of all ones, where the counter runs through its full range. For each compare value, the expected count, square-wave level and match-pulse total are computed from the number of advances by division and remainder. The count is read back through a capture taken while the counter is stopped. Shorter sweeps cover event counting with the tick held high. A timed capture that lands on the clearing edge covers the same-cycle case.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic {
    SRC_TICK  = 1'b0,
    SRC_EVENT = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], d_i};
    last_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o,
  output logic          sq_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sq_q, sq_d;
  logic          hit_q, hit_d;

  always_comb begin
    cnt_d = cnt_q;
    sq_d  = sq_q;
    hit_d = 1'b0;
    if (inc_i) begin
      if (cnt_q == cmp_i) begin
        cnt_d = '0;
        sq_d  = ~sq_q;
        hit_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
      hit_q <= hit_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sq_o  = sq_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/ect_capture.sv
module ect_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cap_o,
  output logic          irq_o
);
  logic [CW-1:0] cap_q, cap_d;
  logic          irq_q, irq_d;

  always_comb begin
    cap_d = cap_q;
    irq_d = take_i;
    if (take_i) cap_d = cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      irq_q <= irq_d;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/evt_capture_timer.sv
module evt_capture_timer #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          src_sel_i,
  input  logic          run_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] cmp_wdata_i,
  input  logic          evt_i,
  input  logic          cap_i,
  output logic [CW-1:0] cap_val_o,
  output logic          sq_o,
  output logic          cap_irq_o,
  output logic          cmp_irq_o
);
  import ect_pkg::*;

  localparam int NPIN = 2;
  localparam int PIN_EVT = 0;
  localparam int PIN_CAP = 1;

  logic [NPIN-1:0] pin_w, rise_w;
  logic [CW-1:0]   cmp_q, cmp_d;
  logic [CW-1:0]   cnt_w;
  logic            inc_w;
  cnt_src_e        src_w;

  assign pin_w[PIN_EVT] = evt_i;
  assign pin_w[PIN_CAP] = cap_i;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    ect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pin_w[g]),
      .rise_o (rise_w[g])
    );
  end

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_we_i) cmp_d = cmp_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '1;
    else        cmp_q <= cmp_d;
  end

  always_comb begin
    src_w = cnt_src_e'(src_sel_i);
    inc_w = 1'b0;
    if (run_i) begin
      if (src_w == SRC_EVENT) inc_w = rise_w[PIN_EVT];
      else                    inc_w = tick_i;
    end
  end

  ect_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (inc_w),
    .cmp_i (cmp_q),
    .cnt_o (cnt_w),
    .sq_o  (sq_o),
    .hit_o (cmp_irq_o)
  );

  ect_capture #(.CW(CW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (rise_w[PIN_CAP]),
    .cnt_i  (cnt_w),
    .cap_o  (cap_val_o),
    .irq_o  (cap_irq_o)
  );
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic          cmp_we_i,
  input logic [CW-1:0] cmp_wdata_i,
  input logic [CW-1:0] cnt_w,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] cap_val_o,
  input logic          sq_o,
  input logic          cap_irq_o,
  input logic          cmp_irq_o
);
  assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(cnt_w) && $stable(sq_o)));

  assert_step_or_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_w) |-> ((cnt_w == CW'($past(cnt_w) + 1'b1)) || (cnt_w == '0)));

  assert_toggle_at_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_o) |-> (cmp_irq_o && (cnt_w == '0)));

  assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq_o |-> ((cnt_w == '0) && !$stable(sq_o)));

  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq_o |-> (cap_val_o == $past(cnt_w)));

  assert_capture_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_irq_o |-> $stable(cap_val_o));

  assert_compare_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i |=> (cmp_q == $past(cmp_wdata_i)));
endmodule

bind evt_capture_timer ect_checker #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_i       (run_i),
  .cmp_we_i    (cmp_we_i),
  .cmp_wdata_i (cmp_wdata_i),
  .cnt_w       (cnt_w),
  .cmp_q       (cmp_q),
  .cap_val_o   (cap_val_o),
  .sq_o        (sq_o),
  .cap_irq_o   (cap_irq_o),
  .cmp_irq_o   (cmp_irq_o)
);

// File: tb/tb_evt_capture_timer.sv
`timescale 1ns/1ps
module tb_evt_capture_timer;
  localparam int CW = 6;
  localparam int MAXV = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_i, src_sel_i, run_i, cmp_we_i, evt_i, cap_i;
  logic [CW-1:0] cmp_wdata_i;
  logic [CW-1:0] cap_val_o;
  logic          sq_o, cap_irq_o, cmp_irq_o;

  int checks = 0;
  int failures = 0;
  int n_cmp = 0;
  int n_cap = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  evt_capture_timer #(.CW(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .src_sel_i(src_sel_i),
    .run_i(run_i), .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .evt_i(evt_i), .cap_i(cap_i), .cap_val_o(cap_val_o), .sq_o(sq_o),
    .cap_irq_o(cap_irq_o), .cmp_irq_o(cmp_irq_o)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && cmp_irq_o) n_cmp <= n_cmp + 1;
    if (rst_n && cap_irq_o) n_cap <= n_cap + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 0; src_sel_i = 0; run_i = 0; cmp_we_i = 0;
    cmp_wdata_i = '0; evt_i = 0; cap_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cmp(input int c);
    @(negedge clk);
    cmp_we_i = 1'b1; cmp_wdata_i = CW'(c);
    @(negedge clk);
    cmp_we_i = 1'b0;
  endtask

  task automatic run_ticks(input int m);
    @(negedge clk);
    src_sel_i = 1'b0; tick_i = 1'b1; run_i = 1'b1;
    repeat (m) @(posedge clk);
    @(negedge clk);
    run_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic pulse_evts(input int n, input bit src, input bit tk);
    @(negedge clk);
    src_sel_i = src; tick_i = tk; run_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_i = 1'b1;
      @(negedge clk); evt_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    run_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic read_cap(output int v);
    @(negedge clk); cap_i = 1'b1;
    @(negedge clk); cap_i = 1'b0;
    repeat (4) @(negedge clk);
    v = int'(cap_val_o);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int v, v2, c0, p0, m, n;
    bit s0;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    chk(cap_val_o == '0, "R1 capture", int'(cap_val_o), 0);
    chk(sq_o == 1'b0, "R1 output", int'(sq_o), 0);
    chk(!cap_irq_o && !cmp_irq_o, "R1 pulses", int'({cap_irq_o, cmp_irq_o}), 0);
    read_cap(v);
    chk(v == 0, "R1 count", v, 0);

    // R1 default compare all ones: full-range wrap
    do_reset();
    c0 = n_cmp;
    run_ticks(100);
    read_cap(v);
    chk(v == 100 % MAXV, "R1 default compare count", v, 100 % MAXV);
    chk(sq_o == 1'b1, "R1 default compare output", int'(sq_o), 1);
    chk(n_cmp - c0 == 1, "R5 default compare pulses", n_cmp - c0, 1);

    // R2 R4 R5 R6 R9 exhaustive compare sweep in tick mode
    for (int c = 0; c < MAXV; c++) begin
      do_reset();
      write_cmp(c);
      m = 2 * c + 5;
      c0 = n_cmp;
      run_ticks(m);
      p0 = n_cap;
      read_cap(v);
      chk(v == m % (c + 1), "R2 R4 count after ticks", v, m % (c + 1));
      chk(int'(sq_o) == ((m / (c + 1)) & 1), "R4 square output", int'(sq_o), (m / (c + 1)) & 1);
      chk(n_cmp - c0 == m / (c + 1), "R5 match pulses", n_cmp - c0, m / (c + 1));
      chk(n_cap - p0 == 1, "R6 capture pulse", n_cap - p0, 1);
    end

    // R3 event counting, tick held high and ignored
    for (int c = 0; c < 16; c++) begin
      do_reset();
      write_cmp(c);
      n = c + 3;
      pulse_evts(n, 1'b1, 1'b1);
      read_cap(v);
      chk(v == n % (c + 1), "R3 event count", v, n % (c + 1));
    end

    // R2 event pin ignored in tick mode
    do_reset();
    write_cmp(20);
    pulse_evts(7, 1'b0, 1'b0);
    read_cap(v);
    chk(v == 0, "R2 events ignored in tick mode", v, 0);

    // R8 hold while stopped
    do_reset();
    write_cmp(40);
    run_ticks(13);
    read_cap(v);
    s0 = sq_o;
    @(negedge clk); tick_i = 1'b1; src_sel_i = 1'b0;
    repeat (20) @(negedge clk);
    src_sel_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); evt_i = 1'b1;
      @(negedge clk); evt_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    tick_i = 1'b0; src_sel_i = 1'b0;
    read_cap(v2);
    chk(v2 == v && v == 13, "R8 count held", v2, 13);
    chk(sq_o == s0, "R8 output held", int'(sq_o), int'(s0));

    // R9 rewrite compare
    do_reset();
    write_cmp(10);
    write_cmp(3);
    run_ticks(9);
    read_cap(v);
    chk(v == 1, "R9 latest compare used", v, 1);

    // R7 capture on the clearing edge
    do_reset();
    write_cmp(5);
    p0 = n_cap;
    @(negedge clk);
    src_sel_i = 1'b0; tick_i = 1'b1; run_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); cap_i = 1'b1;
    @(negedge clk); cap_i = 1'b0;
    repeat (4) @(negedge clk);
    run_i = 1'b0; tick_i = 1'b0;
    @(negedge clk);
    chk(cap_val_o == CW'(5), "R7 count before clear", int'(cap_val_o), 5);
    chk(n_cap - p0 == 1, "R6 coincident capture pulse", n_cap - p0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule